// File: doc/BRIEF.md
# GPIO Wake Event Router

This block lives inside a power management controller. It takes event pulses from sixteen general-purpose pins, eight in the core power domain and eight in the suspend power domain. A two-bit route code per pin steers each event to the system control interrupt (SCI) path, to the system management interrupt (SMI) path, or to neither. An event leaves a sticky status bit only when its route code picks that path and the pin's enable bit for that path is set.

The SCI register also latches sixteen other event inputs. These latch whether or not they are enabled, and one of them acts as a global status that raises SCI on its own. Software programs the block and clears status through a small register port. Status bits are cleared by writing a one to them.

The SCI output is the OR of every enabled status bit, gated by a master enable, plus the global status. The SMI output is the OR of every enabled SMI status bit. Both outputs are decoded from registers, so they follow the status one clock edge after the event.

Top module: `gpio_evt_router`

## Requirements
- R1: After synchronous reset, every register reads 0 and `sci_o` and `smi_o` are 0.
- R2: Pin numbering is `{core_evt, sus_evt}`: suspend pin k is index k and core pin k is index 8+k. Pin i's route code sits at bits [2i+1:2i] of the route register (address 0). With code 2'b10, an event on pin i sets SCI status bit 16+i (address 1) only when SCI enable bit 16+i (address 2) is 1.
- R3: With code 2'b01, an event on pin i sets SMI status bit 16+i only when SMI enable bit i is 1. Both fields are in the SMI register (address 3): status in [31:16], enables in [15:0].
- R4: With route code 2'b00 or 2'b11, an event on a pin sets neither its SCI nor its SMI status bit. A route code that picks the other path leaves this path's status bit clear as well.
- R5: `misc_evt[j]` sets SCI status bit j (j in 0..15) whether or not SCI enable bit j is set.
- R6: Status bits hold until software writes them. Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R7: When an event and a write-one clear reach the same status bit in the same cycle, the bit ends up set.
- R8: `sci_o` is 1 when SCI status bit 0 (the global status) is 1, regardless of any enable. Otherwise `sci_o` is 1 when the master enable (bit 0 of address 4) is 1 and some SCI status bit has its enable bit set.
- R9: `smi_o` is 1 exactly when, for some pin i, SMI status bit 16+i and SMI enable bit i are both 1.
- R10: The route register, SCI enable register and SMI enable half read back what was written. The control register reads only bit 0. Addresses 5 to 7 read 0. A write to the SMI register never sets a status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core_evt | input | 8 | Core-domain pin event pulses |
| sus_evt | input | 8 | Suspend-domain pin event pulses |
| misc_evt | input | 16 | Other SCI events; bit 0 is the global status event |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| sci_o | output | 1 | System control interrupt request |
| smi_o | output | 1 | System management interrupt request |

## Verification
A status bit changes at the first rising edge where its event or its clearing write is present. `sci_o`, `smi_o` and the read data follow the register state without further delay. The bench therefore changes stimulus on the falling edge and holds it for exactly one rising edge. It reads status and outputs on the following falling edge, one clock after the stimulus, with reads given a short settle delay after the address is set. The main sweep covers every pin, every route code and both enable settings. Each case starts from cleared status, so one event maps to one expected register value.

// File: rtl/gpr_pkg.sv
package gpr_pkg;

    localparam int N_CORE   = 8;
    localparam int N_SUS    = 8;
    localparam int N_GPIO   = N_CORE + N_SUS;
    localparam int N_MISC   = 16;
    localparam int DW       = 32;
    localparam int AW       = 3;
    localparam int RT_W     = 2;
    localparam int ROUTE_W  = RT_W * N_GPIO;
    localparam int GPIO_LSB = DW - N_GPIO;
    localparam int GLB_BIT  = 0;

    localparam logic [AW-1:0] ADDR_ROUTE   = 3'd0;
    localparam logic [AW-1:0] ADDR_SCI_STS = 3'd1;
    localparam logic [AW-1:0] ADDR_SCI_EN  = 3'd2;
    localparam logic [AW-1:0] ADDR_SMI     = 3'd3;
    localparam logic [AW-1:0] ADDR_CTRL    = 3'd4;

    typedef enum logic [RT_W-1:0] {
        RT_NONE = 2'b00,
        RT_SMI  = 2'b01,
        RT_SCI  = 2'b10,
        RT_OFF  = 2'b11
    } route_e;

    typedef struct packed {
        logic          we;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
    } regwr_t;

    typedef struct packed {
        logic [N_GPIO-1:0] sci;
        logic [N_GPIO-1:0] smi;
    } gpio_set_t;

    function automatic route_e route_at(input logic [ROUTE_W-1:0] rr, input int idx);
        return route_e'(rr[RT_W*idx +: RT_W]);
    endfunction

    function automatic logic hits(input regwr_t w, input logic [AW-1:0] a);
        return w.we && (w.addr == a);
    endfunction

endpackage

// File: rtl/gpr_route_decode.sv
module gpr_route_decode
    import gpr_pkg::*;
#(
    parameter int N = N_GPIO
) (
    input  logic [RT_W*N-1:0] route,
    input  logic [N-1:0]      evt,
    input  logic [N-1:0]      sci_en,
    input  logic [N-1:0]      smi_en,
    output logic [N-1:0]      sci_set,
    output logic [N-1:0]      smi_set
);

    for (genvar i = 0; i < N; i++) begin : g_pin
        route_e code;
        assign code = route_e'(route[RT_W*i +: RT_W]);

        always_comb begin
            sci_set[i] = 1'b0;
            smi_set[i] = 1'b0;
            unique case (code)
                RT_SCI:  sci_set[i] = evt[i] & sci_en[i];
                RT_SMI:  smi_set[i] = evt[i] & smi_en[i];
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/gpr_w1c_bank.sv
module gpr_w1c_bank #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set,
    input  logic [W-1:0] clr,
    output logic [W-1:0] q
);

    logic [W-1:0] q_nxt;

    always_comb begin
        q_nxt = (q & ~clr) | set;
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= q_nxt;
    end

endmodule

// File: rtl/gpio_evt_router.sv
module gpio_evt_router
    import gpr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [N_CORE-1:0] core_evt,
    input  logic [N_SUS-1:0]  sus_evt,
    input  logic [N_MISC-1:0] misc_evt,
    input  logic              reg_we,
    input  logic [AW-1:0]     reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    output logic              sci_o,
    output logic              smi_o
);

    localparam int SCI_W = N_GPIO + N_MISC;

    logic [N_GPIO-1:0]  gpio_evt;
    regwr_t             wr;
    logic [ROUTE_W-1:0] route_q;
    logic [DW-1:0]      sci_en_q;
    logic [N_GPIO-1:0]  smi_en_q;
    logic               master_q;
    logic [DW-1:0]      sci_sts_q;
    logic [N_GPIO-1:0]  smi_sts_q;
    gpio_set_t          gset;
    logic [DW-1:0]      sci_clr;
    logic [N_GPIO-1:0]  smi_clr;

    assign gpio_evt = {core_evt, sus_evt};
    assign wr       = '{we: reg_we, addr: reg_addr, wdata: reg_wdata};

    // plain read/write configuration registers
    always_ff @(posedge clk) begin
        if (rst) begin
            route_q  <= '0;
            sci_en_q <= '0;
            smi_en_q <= '0;
            master_q <= 1'b0;
        end else if (wr.we) begin
            case (wr.addr)
                ADDR_ROUTE:  route_q  <= wr.wdata[ROUTE_W-1:0];
                ADDR_SCI_EN: sci_en_q <= wr.wdata;
                ADDR_SMI:    smi_en_q <= wr.wdata[N_GPIO-1:0];
                ADDR_CTRL:   master_q <= wr.wdata[0];
                default:     ;
            endcase
        end
    end

    gpr_route_decode #(.N(N_GPIO)) u_decode (
        .route   (route_q),
        .evt     (gpio_evt),
        .sci_en  (sci_en_q[DW-1 -: N_GPIO]),
        .smi_en  (smi_en_q),
        .sci_set (gset.sci),
        .smi_set (gset.smi)
    );

    assign sci_clr = hits(wr, ADDR_SCI_STS) ? wr.wdata : '0;
    assign smi_clr = hits(wr, ADDR_SMI) ? wr.wdata[DW-1 -: N_GPIO] : '0;

    gpr_w1c_bank #(.W(SCI_W)) u_sci_sts (
        .clk (clk),
        .rst (rst),
        .set ({gset.sci, misc_evt}),
        .clr (sci_clr),
        .q   (sci_sts_q)
    );

    gpr_w1c_bank #(.W(N_GPIO)) u_smi_sts (
        .clk (clk),
        .rst (rst),
        .set (gset.smi),
        .clr (smi_clr),
        .q   (smi_sts_q)
    );

    always_comb begin
        sci_o = sci_sts_q[GLB_BIT] | (master_q & (|(sci_sts_q & sci_en_q)));
        smi_o = |(smi_sts_q & smi_en_q);
    end

    always_comb begin
        case (reg_addr)
            ADDR_ROUTE:   reg_rdata = route_q;
            ADDR_SCI_STS: reg_rdata = sci_sts_q;
            ADDR_SCI_EN:  reg_rdata = sci_en_q;
            ADDR_SMI:     reg_rdata = {smi_sts_q, smi_en_q};
            ADDR_CTRL:    reg_rdata = {{(DW-1){1'b0}}, master_q};
            default:      reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/gpio_evt_router_chk.sv
module gpio_evt_router_chk
    import gpr_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic [N_CORE-1:0]  core_evt,
    input logic [N_SUS-1:0]   sus_evt,
    input logic [N_MISC-1:0]  misc_evt,
    input logic               reg_we,
    input logic [AW-1:0]      reg_addr,
    input logic [DW-1:0]      reg_wdata,
    input logic [ROUTE_W-1:0] route_q,
    input logic [DW-1:0]      sci_en_q,
    input logic [N_GPIO-1:0]  smi_en_q,
    input logic [DW-1:0]      sci_sts_q,
    input logic [N_GPIO-1:0]  smi_sts_q
);

    logic [N_GPIO-1:0] g;
    logic              sci_wr;
    logic              smi_wr;
    assign g      = {core_evt, sus_evt};
    assign sci_wr = reg_we && (reg_addr == ADDR_SCI_STS);
    assign smi_wr = reg_we && (reg_addr == ADDR_SMI);

    for (genvar i = 0; i < N_GPIO; i++) begin : g_pin
        p_sci_latch_r2: assert property (@(posedge clk) disable iff (rst)
            (g[i] && route_q[2*i +: 2] == 2'b10 && sci_en_q[GPIO_LSB+i]) |=> sci_sts_q[GPIO_LSB+i]);

        p_smi_latch_r3: assert property (@(posedge clk) disable iff (rst)
            (g[i] && route_q[2*i +: 2] == 2'b01 && smi_en_q[i]) |=> smi_sts_q[i]);

        p_no_sci_latch_r4: assert property (@(posedge clk) disable iff (rst)
            (!sci_sts_q[GPIO_LSB+i] && !(route_q[2*i +: 2] == 2'b10 && sci_en_q[GPIO_LSB+i]))
            |=> !sci_sts_q[GPIO_LSB+i]);

        p_no_smi_latch_r4: assert property (@(posedge clk) disable iff (rst)
            (!smi_sts_q[i] && !(route_q[2*i +: 2] == 2'b01 && smi_en_q[i])) |=> !smi_sts_q[i]);

        p_smi_sticky_r6: assert property (@(posedge clk) disable iff (rst)
            (smi_sts_q[i] && !(smi_wr && reg_wdata[GPIO_LSB+i])) |=> smi_sts_q[i]);
    end

    for (genvar j = 0; j < N_MISC; j++) begin : g_misc
        p_misc_latch_r5: assert property (@(posedge clk) disable iff (rst)
            misc_evt[j] |=> sci_sts_q[j]);
    end

    for (genvar b = 0; b < DW; b++) begin : g_bit
        p_sci_sticky_r6: assert property (@(posedge clk) disable iff (rst)
            (sci_sts_q[b] && !(sci_wr && reg_wdata[b])) |=> sci_sts_q[b]);
    end

endmodule

bind gpio_evt_router gpio_evt_router_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .core_evt  (core_evt),
    .sus_evt   (sus_evt),
    .misc_evt  (misc_evt),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .route_q   (route_q),
    .sci_en_q  (sci_en_q),
    .smi_en_q  (smi_en_q),
    .sci_sts_q (sci_sts_q),
    .smi_sts_q (smi_sts_q)
);

// File: tb/gpio_evt_router_bench.sv
module gpio_evt_router_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  core_evt;
    logic [7:0]  sus_evt;
    logic [15:0] misc_evt;
    logic        reg_we;
    logic [2:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        sci_o;
    logic        smi_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    gpio_evt_router u_gpio_evt_router (
        .clk       (clk),
        .rst       (rst),
        .core_evt  (core_evt),
        .sus_evt   (sus_evt),
        .misc_evt  (misc_evt),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .sci_o     (sci_o),
        .smi_o     (smi_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic pulse(input logic [15:0] gp, input logic [15:0] m);
        @(negedge clk);
        {core_evt, sus_evt} = gp; misc_evt = m;
        @(negedge clk);
        core_evt = '0; sus_evt = '0; misc_evt = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        rst = 1'b1; core_evt = '0; sus_evt = '0; misc_evt = '0;
        reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), v);
            chk("R1 reg", v, 32'h0);
        end
        chk("R1 sci_o", {31'd0, sci_o}, 32'd0);
        chk("R1 smi_o", {31'd0, smi_o}, 32'd0);

        // R2/R3/R4/R9: every pin x route code x enable
        wr(3'd4, 32'h1);
        for (int i = 0; i < 16; i++) begin
            for (int c = 0; c < 4; c++) begin
                for (int e = 0; e < 2; e++) begin
                    logic [31:0] exp_sci;
                    logic [15:0] exp_smi;
                    string       req;
                    exp_sci = (c == 2 && e == 1) ? (32'h1 << (16 + i)) : 32'h0;
                    exp_smi = (c == 1 && e == 1) ? (16'h1 << i) : 16'h0;
                    req = (c == 2) ? "R2" : ((c == 1) ? "R3" : "R4");
                    wr(3'd0, 32'(c) << (2 * i));
                    wr(3'd2, (e == 1) ? (32'h1 << (16 + i)) : 32'h0);
                    wr(3'd3, (e == 1) ? (32'h1 << i) : 32'h0);
                    pulse(16'h1 << i, 16'h0);
                    rd(3'd1, v);
                    chk({req, " sci status"}, v, exp_sci);
                    rd(3'd3, v);
                    chk({req, " smi status"}, {16'h0, v[31:16]}, {16'h0, exp_smi});
                    chk("R8 sci_o", {31'd0, sci_o}, {31'd0, exp_sci != 0});
                    chk("R9 smi_o", {31'd0, smi_o}, {31'd0, exp_smi != 0});
                    wr(3'd1, 32'hFFFF_FFFF);
                    wr(3'd3, 32'hFFFF_0000);
                end
            end
        end
        wr(3'd0, 32'h0);

        // R5/R8: non-GPIO event latches without enable, master gating
        wr(3'd4, 32'h0);
        wr(3'd2, 32'h0);
        pulse(16'h0, 16'h0002);
        rd(3'd1, v);
        chk("R5 misc latch", v, 32'h2);
        chk("R8 no enable", {31'd0, sci_o}, 32'd0);
        wr(3'd2, 32'h2);
        chk("R8 master off", {31'd0, sci_o}, 32'd0);
        wr(3'd4, 32'h1);
        chk("R8 master on", {31'd0, sci_o}, 32'd1);
        wr(3'd1, 32'h2);
        chk("R8 cleared", {31'd0, sci_o}, 32'd0);
        wr(3'd4, 32'h0);
        wr(3'd2, 32'h0);
        pulse(16'h0, 16'h0001);
        rd(3'd1, v);
        chk("R5 global latch", v, 32'h1);
        chk("R8 global override", {31'd0, sci_o}, 32'd1);

        // R6: sticky, write-one-to-clear only
        pulse(16'h0, 16'h0F00);
        rd(3'd1, v);
        chk("R6 accumulate", v, 32'h0F01);
        wr(3'd1, 32'h0);
        rd(3'd1, v);
        chk("R6 write zero", v, 32'h0F01);
        wr(3'd1, 32'h0000_0100);
        rd(3'd1, v);
        chk("R6 single clear", v, 32'h0E01);
        wr(3'd1, 32'hFFFF_FFFF);
        rd(3'd1, v);
        chk("R6 full clear", v, 32'h0);

        // R7: event and clear in the same cycle
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 3'd1; reg_wdata = 32'h4; misc_evt = 16'h4;
        @(negedge clk);
        reg_we = 1'b0; misc_evt = '0;
        rd(3'd1, v);
        chk("R7 sci set wins", v, 32'h4);
        wr(3'd0, 32'h0000_0040);
        wr(3'd3, 32'h0000_0008);
        pulse(16'h0008, 16'h0);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 3'd3; reg_wdata = 32'h0008_0008; sus_evt = 8'h08;
        @(negedge clk);
        reg_we = 1'b0; sus_evt = '0;
        rd(3'd3, v);
        chk("R7 smi set wins", v, 32'h0008_0008);
        chk("R9 smi_o", {31'd0, smi_o}, 32'd1);

        // R10: readback
        wr(3'd0, 32'hA5C3_1E7F);
        rd(3'd0, v);
        chk("R10 route", v, 32'hA5C3_1E7F);
        wr(3'd2, 32'h5A5A_0F0F);
        rd(3'd2, v);
        chk("R10 sci enable", v, 32'h5A5A_0F0F);
        wr(3'd4, 32'hFFFF_FFFF);
        rd(3'd4, v);
        chk("R10 ctrl", v, 32'h1);
        wr(3'd3, 32'hFFFF_FFFF);
        rd(3'd3, v);
        chk("R10 smi write", v, 32'h0000_FFFF);
        for (int a = 5; a < 8; a++) begin
            rd(3'(a), v);
            chk("R10 unmapped", v, 32'h0);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule